// File: doc/BRIEF.md
# Serial Channel Receive Stream Tagger

This block is the control and receive-data path for one channel of a serial interface card. Each data word from the serial controller is turned into a short burst of receive FIFO entries. The data word always comes first. A status word can follow it, and then a 24-bit timestamp, if each is enabled. Every entry carries a two-bit kind tag. The FIFO storage, the serial controller and host bus decoding sit outside the block. A small register port gives the host access to an 8-bit control register and a sync-match register.

The control register sets the two stream enables. It also fires single-cycle reset pulses: one for the serial controller, one for the channel, one for the receive FIFO and one for the transmit FIFO. The serial controller serves two channels, so a pulse on its reset output reaches both channels of the pair. Each data entry is compared with a programmable sync byte as it is pushed. A match raises a one-cycle event that an interrupt controller can pick up. A free-running 24-bit counter supplies the timestamps.

Top module: `rx_stream_tagger`

## Requirements
- R1: A write to address 0 with bit 7 set gives a high `ser_ctrl_rst` for exactly the one cycle after the write. Bit 7 always reads back as 0.
- R2: A write to address 0 with bit 6 set gives a one-cycle `chan_rst` pulse in the cycle after the write. During that pulse, any pending stream entries are dropped. From the next cycle, `rx_ready` is high and nothing is pushed.
- R3: A write to address 0 with bit 1 set gives a one-cycle `rx_fifo_rst` pulse. Bit 0 does the same for `tx_fifo_rst`. Each pulse comes in the cycle after the write, and both bits read back as 0.
- R4: Every write to address 0 stores bit 3 as the status enable and bit 2 as the timestamp enable. A read of address 0 returns these two bits in place, and every other bit reads as 0, including reserved bits 5:4.
- R5: Address 1 stores the sync byte from bits 7:0. A read returns that byte, and bits 31:8 read as 0.
- R6: A word is accepted in a cycle where `rx_valid` and `rx_ready` are high. In the next cycle, `fifo_push` is high, `fifo_kind` is 0 (data) and `fifo_data` holds `rx_data` zero-extended.
- R7: The entries of one word go out in consecutive cycles. The data entry comes first, then status (kind 1, `rx_status` zero-extended) if enabled, then timestamp (kind 2) if enabled. `rx_ready` stays low while entries are pending and goes high in the cycle after the last one.
- R8: A timestamp entry holds the 24-bit counter value from the acceptance cycle. The counter is 0 in the first cycle after reset and counts up by one every cycle, modulo 2^24.
- R9: `sync_evt` is high for exactly the data-entry cycle, and only when bits 7:0 of the data equal the sync byte. It never rises for status or timestamp entries.
- R10: A word presented while `chan_rst` or `rx_fifo_rst` is high is discarded, and no entry follows it.
- R11: The stream enables are sampled when a word is accepted. A control write made while that word's entries are going out does not change them.
- R12: After reset, all pulses, `fifo_push` and `sync_evt` are low, `rx_ready` is high, and both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 sync byte) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rx_valid | input | 1 | Received word present |
| rx_ready | output | 1 | Block can accept a word |
| rx_data | input | 16 | Received data word |
| rx_status | input | 16 | Receive status for the word |
| fifo_push | output | 1 | Write one entry to the receive FIFO |
| fifo_kind | output | 2 | Entry kind: 0 data, 1 status, 2 timestamp |
| fifo_data | output | 32 | Entry value, zero-extended |
| sync_evt | output | 1 | Sync byte matched on the data entry being pushed |
| ser_ctrl_rst | output | 1 | Reset pulse to the shared serial controller |
| chan_rst | output | 1 | Channel reset pulse |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |

## Verification
Words are sent under all four enable combinations: plain, status only, timestamp only, and both. This separates entry order and burst length from any fixed sequence. Timestamps are compared with a cycle count kept by the bench. Words are sent with different gaps between them, which exposes a counter sampled in the wrong cycle. Sync tests use a data word whose low byte matches and a word that differs by one bit. A status word that carries the sync byte in its low byte shows that only data entries are compared. Further cases cover:
- a word offered during each flush pulse;
- a channel reset in the middle of a burst;
- a control write during a burst, which shows whether the enables are latched at acceptance.

// File: rtl/rxtag_pkg.sv
// Package: shared encodings for the receive stream tagger.
// Assumes a 32-bit register data path and a two-bit entry kind field.
package rxtag_pkg;

    // Kind tag attached to every receive FIFO entry
    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_STATUS = 2'd1,
        KIND_STAMP  = 2'd2
    } entry_kind_t;

    // Register addresses
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_SYNC = 1;

    // Control register bit positions
    localparam int unsigned CB_SER_RST  = 7;
    localparam int unsigned CB_CHAN_RST = 6;
    localparam int unsigned CB_STAT_EN  = 3;
    localparam int unsigned CB_TS_EN    = 2;
    localparam int unsigned CB_RXF_RST  = 1;
    localparam int unsigned CB_TXF_RST  = 0;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned SYNC_W = 8;

endpackage

// File: rtl/rxtag_regs.sv
// Module: control and sync-byte registers with self-clearing reset pulses.
// Every control write updates both enables; pulse bits are not stored and
// read as zero. Reads are combinational from the address.
module rxtag_regs
    import rxtag_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              stat_en,
    output logic              ts_en,
    output logic [SYNC_W-1:0] sync_byte,
    output logic              ser_ctrl_rst,
    output logic              chan_rst,
    output logic              rx_fifo_rst,
    output logic              tx_fifo_rst
);

    logic wr_ctrl;
    logic wr_sync;

    // Decode register write targets
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        wr_sync = reg_wr && (reg_addr == ADDR_W'(ADDR_SYNC));
    end

    // Store enables and sync byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_en   <= 1'b0;
            ts_en     <= 1'b0;
            sync_byte <= '0;
        end else begin
            if (wr_ctrl) begin
                stat_en <= reg_wdata[CB_STAT_EN];
                ts_en   <= reg_wdata[CB_TS_EN];
            end
            if (wr_sync) begin
                sync_byte <= reg_wdata[SYNC_W-1:0];
            end
        end
    end

    // Generate one-cycle reset pulses from control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_ctrl_rst <= 1'b0;
            chan_rst     <= 1'b0;
            rx_fifo_rst  <= 1'b0;
            tx_fifo_rst  <= 1'b0;
        end else begin
            ser_ctrl_rst <= wr_ctrl && reg_wdata[CB_SER_RST];
            chan_rst     <= wr_ctrl && reg_wdata[CB_CHAN_RST];
            rx_fifo_rst  <= wr_ctrl && reg_wdata[CB_RXF_RST];
            tx_fifo_rst  <= wr_ctrl && reg_wdata[CB_TXF_RST];
        end
    end

    // Read multiplexer; pulse and reserved bits return zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[CB_STAT_EN] = stat_en;
            reg_rdata[CB_TS_EN]   = ts_en;
        end else if (reg_addr == ADDR_W'(ADDR_SYNC)) begin
            reg_rdata[SYNC_W-1:0] = sync_byte;
        end
    end

endmodule

// File: rtl/rxtag_tstamp.sv
// Module: free-running timestamp counter.
// Zero in the first cycle after reset, wraps at 2^TS_W.
module rxtag_tstamp #(
    parameter int unsigned TS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] count
);

    // Advance by one every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rxtag_seq.sv
// Module: receive stream sequencer.
// Captures a word, its status, the timestamp and both enables at acceptance,
// then pushes data, optional status and optional timestamp, one per cycle.
// Assumes FIFO_W is at least DATA_W, STAT_W and TS_W.
module rxtag_seq
    import rxtag_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAT_W = 16,
    parameter int unsigned TS_W   = 24,
    parameter int unsigned FIFO_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_seq,
    input  logic              block_in,
    input  logic              stat_en,
    input  logic              ts_en,
    input  logic [SYNC_W-1:0] sync_byte,
    input  logic [TS_W-1:0]   ts_now,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [STAT_W-1:0] rx_status,
    output logic              fifo_push,
    output logic [1:0]        fifo_kind,
    output logic [FIFO_W-1:0] fifo_data,
    output logic              sync_evt
);

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STAT, ST_STAMP} seq_state_t;

    seq_state_t        state;
    logic [DATA_W-1:0] data_q;
    logic [STAT_W-1:0] stat_q;
    logic [TS_W-1:0]   ts_q;
    logic              stat_en_q;
    logic              ts_en_q;
    logic              accept;

    // Accept only when idle and no flush pulse is present
    always_comb begin
        rx_ready = (state == ST_IDLE);
        accept   = rx_valid && rx_ready && !block_in;
    end

    // Capture the word and its context at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            stat_q    <= '0;
            ts_q      <= '0;
            stat_en_q <= 1'b0;
            ts_en_q   <= 1'b0;
        end else if (accept) begin
            data_q    <= rx_data;
            stat_q    <= rx_status;
            ts_q      <= ts_now;
            stat_en_q <= stat_en;
            ts_en_q   <= ts_en;
        end
    end

    // Step through the entries of one word
    always_ff @(posedge clk) begin
        if (!rst_n || flush_seq) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept) state <= ST_DATA;
                ST_DATA:  state <= stat_en_q ? ST_STAT : (ts_en_q ? ST_STAMP : ST_IDLE);
                ST_STAT:  state <= ts_en_q ? ST_STAMP : ST_IDLE;
                ST_STAMP: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Drive the FIFO entry and the sync match for the current state
    always_comb begin
        fifo_push = (state != ST_IDLE);
        fifo_kind = KIND_DATA;
        fifo_data = '0;
        sync_evt  = 1'b0;
        unique case (state)
            ST_DATA: begin
                fifo_kind = KIND_DATA;
                fifo_data = FIFO_W'(data_q);
                sync_evt  = (data_q[SYNC_W-1:0] == sync_byte);
            end
            ST_STAT: begin
                fifo_kind = KIND_STATUS;
                fifo_data = FIFO_W'(stat_q);
            end
            ST_STAMP: begin
                fifo_kind = KIND_STAMP;
                fifo_data = FIFO_W'(ts_q);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_stream_tagger.sv
// Module: top of the channel receive stream tagger.
// Connects the registers, the timestamp counter and the sequencer. A channel
// reset aborts a burst; channel and receive FIFO resets both block new words.
module rx_stream_tagger
    import rxtag_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAT_W = 16,
    parameter int unsigned TS_W   = 24,
    parameter int unsigned FIFO_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [STAT_W-1:0] rx_status,
    output logic              fifo_push,
    output logic [1:0]        fifo_kind,
    output logic [FIFO_W-1:0] fifo_data,
    output logic              sync_evt,
    output logic              ser_ctrl_rst,
    output logic              chan_rst,
    output logic              rx_fifo_rst,
    output logic              tx_fifo_rst
);

    logic              stat_en;
    logic              ts_en;
    logic [SYNC_W-1:0] sync_byte;
    logic [TS_W-1:0]   ts_now;
    logic              block_in;

    // Combine the pulses that make incoming words be discarded
    always_comb block_in = chan_rst || rx_fifo_rst;

    rxtag_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .stat_en      (stat_en),
        .ts_en        (ts_en),
        .sync_byte    (sync_byte),
        .ser_ctrl_rst (ser_ctrl_rst),
        .chan_rst     (chan_rst),
        .rx_fifo_rst  (rx_fifo_rst),
        .tx_fifo_rst  (tx_fifo_rst)
    );

    rxtag_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk   (clk),
        .rst_n (rst_n),
        .count (ts_now)
    );

    rxtag_seq #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W),
        .TS_W   (TS_W),
        .FIFO_W (FIFO_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_seq (chan_rst),
        .block_in  (block_in),
        .stat_en   (stat_en),
        .ts_en     (ts_en),
        .sync_byte (sync_byte),
        .ts_now    (ts_now),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .rx_status (rx_status),
        .fifo_push (fifo_push),
        .fifo_kind (fifo_kind),
        .fifo_data (fifo_data),
        .sync_evt  (sync_evt)
    );

endmodule

// File: rtl/rxtag_checker.sv
// Module: protocol checker for rx_stream_tagger, attached by bind.
// Observes top-level ports only.
module rxtag_checker #(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              fifo_push,
    input logic [1:0]        fifo_kind,
    input logic              sync_evt,
    input logic              ser_ctrl_rst,
    input logic              chan_rst,
    input logic              rx_fifo_rst,
    input logic              tx_fifo_rst
);

    logic wr_ctrl;
    always_comb wr_ctrl = reg_wr && (reg_addr == '0);

    a_r1_ser_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[7]) |=> ser_ctrl_rst);
    a_r1_ser_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ctrl_rst |-> $past(wr_ctrl && reg_wdata[7]));
    a_r2_chan_abort: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (rx_ready && !fifo_push));
    a_r3_rxf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst |-> $past(wr_ctrl && reg_wdata[1]));
    a_r3_txf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst |-> $past(wr_ctrl && reg_wdata[0]));
    a_r5_sync_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(1)) |-> (reg_rdata[31:8] == 24'd0));
    a_r6_accept_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !chan_rst && !rx_fifo_rst) |=> (fifo_push && fifo_kind == 2'd0));
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !rx_ready);
    a_r7_status_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_kind == 2'd1) |-> $past(fifo_push && fifo_kind == 2'd0));
    a_r9_sync_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |-> (fifo_push && fifo_kind == 2'd0));
    a_r10_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && (chan_rst || rx_fifo_rst)) |=> !fifo_push);

endmodule

bind rx_stream_tagger rxtag_checker #(.ADDR_W(ADDR_W)) u_rxtag_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .fifo_push    (fifo_push),
    .fifo_kind    (fifo_kind),
    .sync_evt     (sync_evt),
    .ser_ctrl_rst (ser_ctrl_rst),
    .chan_rst     (chan_rst),
    .rx_fifo_rst  (rx_fifo_rst),
    .tx_fifo_rst  (tx_fifo_rst)
);

// File: tb/test_rx_stream_tagger.sv
// Bench: directed scenarios for rx_stream_tagger, one task each.
// Inputs change on the falling edge; outputs are sampled there too.
module test_rx_stream_tagger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [15:0] rx_data = '0;
    logic [15:0] rx_status = '0;
    logic        fifo_push;
    logic [1:0]  fifo_kind;
    logic [31:0] fifo_data;
    logic        sync_evt;
    logic        ser_ctrl_rst;
    logic        chan_rst;
    logic        rx_fifo_rst;
    logic        tx_fifo_rst;

    int unsigned checks = 0;
    int unsigned failures = 0;
    logic [23:0] tb_cyc = '0;
    logic [7:0]  sync_cfg = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    // Cycle count since reset, the reference for timestamps
    always @(posedge clk) tb_cyc <= rst_n ? tb_cyc + 24'd1 : 24'd0;

    rx_stream_tagger i_rx_stream_tagger (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_status(rx_status),
        .fifo_push(fifo_push), .fifo_kind(fifo_kind), .fifo_data(fifo_data),
        .sync_evt(sync_evt), .ser_ctrl_rst(ser_ctrl_rst), .chan_rst(chan_rst),
        .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Offer one word and check its complete burst
    task automatic send_word(input logic [15:0] d, input logic [15:0] s,
                             input bit exp_stat, input bit exp_ts, input string req);
        logic [23:0] exp_stamp;
        @(negedge clk);
        check({req, " ready before word"}, {31'd0, rx_ready}, 32'd1);
        rx_valid = 1'b1; rx_data = d; rx_status = s;
        exp_stamp = tb_cyc;
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " R6 data push"}, {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd0});
        check({req, " R6 data value"}, fifo_data, {16'd0, d});
        check({req, " R9 sync on data"}, {31'd0, sync_evt}, {31'd0, d[7:0] == sync_cfg});
        check({req, " R7 busy"}, {31'd0, rx_ready}, 32'd0);
        if (exp_stat) begin
            @(negedge clk);
            check({req, " R7 status entry"}, {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd1});
            check({req, " R7 status value"}, fifo_data, {16'd0, s});
            check({req, " R9 no sync on status"}, {31'd0, sync_evt}, 32'd0);
        end
        if (exp_ts) begin
            @(negedge clk);
            check({req, " R8 stamp entry"}, {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd2});
            check({req, " R8 stamp value"}, fifo_data, {8'd0, exp_stamp});
        end
        @(negedge clk);
        check({req, " R7 burst end"}, {30'd0, fifo_push, rx_ready}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        check("R12 push/evt", {30'd0, fifo_push, sync_evt}, 32'd0);
        check("R12 ready", {31'd0, rx_ready}, 32'd1);
        check("R12 pulses", {28'd0, ser_ctrl_rst, chan_rst, rx_fifo_rst, tx_fifo_rst}, 32'd0);
        rd_reg(2'd0, v); check("R12 ctrl reads 0", v, 32'd0);
        rd_reg(2'd1, v); check("R12 sync reads 0", v, 32'd0);
    endtask

    task automatic t_registers;
        logic [31:0] v;
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, v); check("R4 ctrl readback all ones", v, 32'h0000_000C);
        wr_reg(2'd0, 32'h0000_0008);
        rd_reg(2'd0, v); check("R4 ctrl status only", v, 32'h0000_0008);
        wr_reg(2'd0, 32'h0000_0030);
        rd_reg(2'd0, v); check("R4 reserved 5:4 read 0", v, 32'd0);
        wr_reg(2'd1, 32'hDEAD_BE5A);
        rd_reg(2'd1, v); check("R5 sync byte upper zero", v, 32'h0000_005A);
        wr_reg(2'd1, 32'd0);
    endtask

    task automatic t_pulses;
        logic [31:0] v;
        wr_reg(2'd0, 32'h80);
        check("R1 ser pulse", {28'd0, ser_ctrl_rst, chan_rst, rx_fifo_rst, tx_fifo_rst}, 32'h8);
        rd_reg(2'd0, v); check("R1 bit7 reads 0", v, 32'd0);
        @(negedge clk);
        check("R1 ser pulse one cycle", {31'd0, ser_ctrl_rst}, 32'd0);
        wr_reg(2'd0, 32'h40);
        check("R2 chan pulse", {28'd0, ser_ctrl_rst, chan_rst, rx_fifo_rst, tx_fifo_rst}, 32'h4);
        @(negedge clk);
        check("R2 chan pulse one cycle", {31'd0, chan_rst}, 32'd0);
        wr_reg(2'd0, 32'h02);
        check("R3 rx fifo pulse", {28'd0, ser_ctrl_rst, chan_rst, rx_fifo_rst, tx_fifo_rst}, 32'h2);
        rd_reg(2'd0, v); check("R3 bit1 reads 0", v, 32'd0);
        wr_reg(2'd0, 32'h01);
        check("R3 tx fifo pulse", {28'd0, ser_ctrl_rst, chan_rst, rx_fifo_rst, tx_fifo_rst}, 32'h1);
        @(negedge clk);
        check("R3 tx pulse one cycle", {31'd0, tx_fifo_rst}, 32'd0);
    endtask

    task automatic t_streams;
        wr_reg(2'd0, 32'h0);
        send_word(16'h1234, 16'h00F0, 1'b0, 1'b0, "R6 plain");
        wr_reg(2'd0, 32'h8);
        send_word(16'hBEEF, 16'h0A0B, 1'b1, 1'b0, "R7 status");
        wr_reg(2'd0, 32'h4);
        send_word(16'h0077, 16'h1111, 1'b0, 1'b1, "R8 stamp");
        repeat (5) @(negedge clk);
        send_word(16'h0078, 16'h2222, 1'b0, 1'b1, "R8 stamp gap");
        wr_reg(2'd0, 32'hC);
        send_word(16'hCAFE, 16'h5555, 1'b1, 1'b1, "R7 both");
        send_word(16'hCAFF, 16'h6666, 1'b1, 1'b1, "R7 both back-to-back");
    endtask

    task automatic t_sync;
        wr_reg(2'd1, 32'hA5); sync_cfg = 8'hA5;
        wr_reg(2'd0, 32'h8);
        send_word(16'h12A5, 16'h00A5, 1'b1, 1'b0, "R9 match");
        send_word(16'h12A4, 16'h00A5, 1'b1, 1'b0, "R9 near miss");
        send_word(16'hA500, 16'h0000, 1'b1, 1'b0, "R9 high byte only");
    endtask

    task automatic t_discard;
        wr_reg(2'd0, 32'h40);
        rx_valid = 1'b1; rx_data = 16'h4242;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R10 discard on chan reset", {31'd0, fifo_push}, 32'd0);
        @(negedge clk);
        check("R10 still nothing after chan reset", {31'd0, fifo_push}, 32'd0);
        wr_reg(2'd0, 32'h02);
        rx_valid = 1'b1; rx_data = 16'h4343;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R10 discard on rx fifo reset", {30'd0, fifo_push, rx_ready}, 32'd1);
    endtask

    task automatic t_abort;
        wr_reg(2'd0, 32'hC);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 16'h0101; rx_status = 16'h0202;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R2 abort data first", {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd0});
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h4C;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R2 status during pulse", {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd1});
        @(negedge clk);
        check("R2 stamp dropped", {30'd0, fifo_push, rx_ready}, 32'd1);
    endtask

    task automatic t_latch;
        wr_reg(2'd0, 32'h4);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 16'h0033;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R11 data", {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd0});
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h8;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R11 latched stamp not status", {29'd0, fifo_push, fifo_kind}, {29'd0, 1'b1, 2'd2});
        @(negedge clk);
        check("R11 burst end", {30'd0, fifo_push, rx_ready}, 32'd1);
    endtask

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R12 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_registers();
        t_pulses();
        t_streams();
        t_sync();
        t_discard();
        t_abort();
        t_latch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule